// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends 8-bit characters on a single serial line. Each frame has a low start bit, the data bits least significant first, and a high stop bit. A one-character holding register sits in front of the shift engine. Software can supply the next byte while the current one is still leaving the line, so consecutive frames follow each other with no idle gap longer than one clock.

Two status flags describe the transmit path. `buf_empty` means the holding register can accept a byte, even if the shift engine is still busy. `path_idle` means that the holding register and the shift engine are both empty, so the last stop bit has fully left the line. Each flag has its own interrupt enable. An enable input hands the pin to the transmitter. A break request holds the line low for whole character times; the request is sampled only between frames.

Bit timing comes from an external baud-tick strobe. Each bit lasts a fixed number of ticks (16 by default).

Top module: `ser_tx_buffered`

## Requirements
- R1: After reset, `buf_empty`=1, `path_idle`=1 and `tx_line`=1. `irq_buf` and `irq_done` are 0 while their enables are 0.
- R2: A frame is one low start bit, then 8 data bits LSB first, then one high stop bit. Each bit lasts 16 baud ticks.
- R3: A write makes both `buf_empty` and `path_idle` read 0 in the next cycle. If the engine is idle and enabled, the byte moves into the shift engine on the following clock. From that clock `tx_line` drives the start bit (0) and `buf_empty` reads 1 while `path_idle` stays 0.
- R4: A byte written while a frame is shifting is kept, and it is sent right after the current frame. `buf_empty` stays 0 until the current frame ends.
- R5: `path_idle` returns to 1 exactly 160 clocks after the start bit began, when one baud tick comes every clock. The line is high whenever `path_idle` is 1 and the transmitter is enabled.
- R6: A write while the holding register is full replaces the byte held there. The replaced byte is never sent.
- R7: A write in the same cycle as a transfer from the holding register sends the older byte first. The new byte stays held and is sent next.
- R8: `irq_buf` equals `irq_empty_en` AND `buf_empty`. `irq_done` equals `irq_done_en` AND `path_idle`.
- R9: While `tx_enable`=0, `tx_oe`=0 and `tx_line` reads 1. No new frame starts and a held byte waits. Once `tx_enable` is set, the held byte is sent.
- R10: When `brk_req` is 1 at a frame boundary, the line goes low for a whole number of character times (160 ticks each). Break takes precedence over a held byte. After `brk_req` drops, the current character time ends, the line returns high, and any held byte is then sent.
- R11: Bit length scales with baud-tick spacing. With one tick every 3 clocks, each bit lasts 48 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-clock strobe; 16 strobes make one bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| tx_enable | input | 1 | Gives the pin to the transmitter and allows frames to start |
| brk_req | input | 1 | Request to hold the line low for whole character times |
| irq_empty_en | input | 1 | Interrupt enable for the holding-register-empty flag |
| irq_done_en | input | 1 | Interrupt enable for the path-drained flag |
| tx_line | output | 1 | Serial output level |
| tx_oe | output | 1 | Output enable for the pin |
| buf_empty | output | 1 | Holding register is free |
| path_idle | output | 1 | Holding register and shift engine are both empty |
| irq_buf | output | 1 | Interrupt request: holding register free |
| irq_done | output | 1 | Interrupt request: path drained |

## Verification
A write and the transfer of the previous byte from the holding register into the shift engine can fall on the same clock edge. The bench provokes this by keeping `wr_en` high for two consecutive cycles while the engine is idle. The scoreboard then has to see the first byte on the line, followed by the second. A second collision happens when a break request and a write arrive together: the bench expects a whole-character low period first, then the held byte.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_FRAME = 2'd1,
        SH_BREAK = 2'd2
    } sh_state_e;

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] data;
    } hold_t;

    // Line level for a given bit slot of a frame: slot 0 start, 1..CHAR_W data, rest stop.
    function automatic logic frame_level(input int unsigned pos, input logic [CHAR_W-1:0] bits);
        logic lvl;
        lvl = 1'b1;
        if (pos == 0) begin
            lvl = 1'b0;
        end
        for (int k = 0; k < CHAR_W; k++) begin
            if (pos == k + 1) begin
                lvl = bits[k];
            end
        end
        return lvl;
    endfunction

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf
    import ser_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              take,
    output hold_t             hold
);

    hold_t hold_q;

    // A write wins over a take: the engine reads the old byte combinationally this cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (wr_en) begin
            hold_q.valid <= 1'b1;
            hold_q.data  <= wr_data;
        end else if (take) begin
            hold_q.valid <= 1'b0;
        end
    end

    assign hold = hold_q;

endmodule

// File: rtl/tx_shift_engine.sv
module tx_shift_engine
    import ser_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int STOP_BITS  = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  enable,
    input  logic  brk_req,
    input  hold_t hold,
    output logic  take,
    output logic  busy,
    output logic  line
);

    localparam int SLOTS = CHAR_W + 1 + STOP_BITS;
    localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int IDX_W = $clog2(SLOTS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOTS - 1);

    sh_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CHAR_W-1:0] shreg_q;
    logic              slot_end;

    assign take     = (state_q == SH_IDLE) && enable && !brk_req && hold.valid;
    assign slot_end = tick && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
        end else begin
            case (state_q)
                SH_IDLE: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                    if (enable && brk_req) begin
                        state_q <= SH_BREAK;
                    end else if (take) begin
                        state_q <= SH_FRAME;
                        shreg_q <= hold.data;
                    end
                end
                SH_FRAME, SH_BREAK: begin
                    if (tick) begin
                        cnt_q <= slot_end ? '0 : cnt_q + 1'b1;
                    end
                    if (slot_end) begin
                        if (idx_q == IDX_LAST) begin
                            idx_q <= '0;
                            if (!(state_q == SH_BREAK && brk_req && enable)) begin
                                state_q <= SH_IDLE;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SH_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state_q)
            SH_FRAME: line = frame_level(int'(idx_q), shreg_q);
            SH_BREAK: line = 1'b0;
            default:  line = 1'b1;
        endcase
    end

    assign busy = (state_q != SH_IDLE);

endmodule

// File: rtl/tx_status.sv
module tx_status (
    input  logic hold_valid,
    input  logic busy,
    input  logic irq_empty_en,
    input  logic irq_done_en,
    output logic buf_empty,
    output logic path_idle,
    output logic irq_buf,
    output logic irq_done
);

    assign buf_empty = !hold_valid;
    assign path_idle = !hold_valid && !busy;
    assign irq_buf   = irq_empty_en && buf_empty;
    assign irq_done  = irq_done_en && path_idle;

endmodule

// File: rtl/ser_tx_buffered.sv
module ser_tx_buffered
    import ser_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int STOP_BITS  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              tx_enable,
    input  logic              brk_req,
    input  logic              irq_empty_en,
    input  logic              irq_done_en,
    output logic              tx_line,
    output logic              tx_oe,
    output logic              buf_empty,
    output logic              path_idle,
    output logic              irq_buf,
    output logic              irq_done
);

    hold_t hold;
    logic  take;
    logic  busy;
    logic  eng_line;

    tx_hold_buf u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .hold    (hold)
    );

    tx_shift_engine #(
        .OVERSAMPLE (OVERSAMPLE),
        .STOP_BITS  (STOP_BITS)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .tick    (baud_tick),
        .enable  (tx_enable),
        .brk_req (brk_req),
        .hold    (hold),
        .take    (take),
        .busy    (busy),
        .line    (eng_line)
    );

    tx_status u_stat (
        .hold_valid   (hold.valid),
        .busy         (busy),
        .irq_empty_en (irq_empty_en),
        .irq_done_en  (irq_done_en),
        .buf_empty    (buf_empty),
        .path_idle    (path_idle),
        .irq_buf      (irq_buf),
        .irq_done     (irq_done)
    );

    assign tx_oe   = tx_enable;
    assign tx_line = tx_enable ? eng_line : 1'b1;

endmodule

// File: rtl/ser_tx_checker.sv
module ser_tx_checker (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic tx_enable,
    input logic tx_line,
    input logic buf_empty,
    input logic path_idle
);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (buf_empty && path_idle && tx_line));

    p_write_clears_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (!buf_empty && !path_idle));

    p_busy_not_drained_r4: assert property (@(posedge clk) disable iff (rst)
        !buf_empty |-> !path_idle);

    p_drained_line_high_r5: assert property (@(posedge clk) disable iff (rst)
        (path_idle && tx_enable) |-> tx_line);

    p_drain_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(path_idle) |-> buf_empty);

    p_held_while_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!tx_enable && !buf_empty) |=> !buf_empty);

endmodule

bind ser_tx_buffered ser_tx_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .tx_enable (tx_enable),
    .tx_line   (tx_line),
    .buf_empty (buf_empty),
    .path_idle (path_idle)
);

// File: tb/test_ser_tx_buffered.sv
`timescale 1ns/1ps
module test_ser_tx_buffered;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tx_enable = 1'b0;
    logic       brk_req = 1'b0;
    logic       irq_empty_en = 1'b0;
    logic       irq_done_en = 1'b0;
    logic       tx_line, tx_oe, buf_empty, path_idle, irq_buf, irq_done;

    int n_checks = 0;
    int n_errors = 0;
    int div = 1;
    int dcnt = 0;

    typedef struct { bit brk; int val; } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    ser_tx_buffered i_ser_tx_buffered (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .tx_enable(tx_enable), .brk_req(brk_req), .irq_empty_en(irq_empty_en),
        .irq_done_en(irq_done_en), .tx_line(tx_line), .tx_oe(tx_oe),
        .buf_empty(buf_empty), .path_idle(path_idle), .irq_buf(irq_buf), .irq_done(irq_done)
    );

    always @(negedge clk) begin
        baud_tick = (dcnt == 0);
        dcnt = dcnt + 1;
        if (dcnt >= div) dcnt = 0;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    task automatic do_write(input logic [7:0] d, input bit push);
        exp_t e;
        wr_en = 1'b1;
        wr_data = d;
        if (push) begin
            e.brk = 1'b0; e.val = int'(d);
            q.push_back(e);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_break(input int len);
        exp_t e;
        e.brk = 1'b1; e.val = len;
        q.push_back(e);
    endtask

    task automatic wait_idle();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!path_idle && guard < 5000);
    endtask

    // Monitor: rebuilds frames from the line and compares with the scoreboard queue.
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (prev && !tx_line && tx_oe) begin : frame_rx
                int d;
                int low;
                logic [7:0] got;
                logic startb, stopb;
                exp_t e;
                d = div;
                repeat (8 * d) @(negedge clk);
                startb = tx_line;
                for (int b = 0; b < 8; b++) begin
                    repeat (16 * d) @(negedge clk);
                    got[b] = tx_line;
                end
                repeat (16 * d) @(negedge clk);
                stopb = tx_line;
                if (q.size() == 0) begin
                    chk("R2", "unexpected frame", 1, 0);
                end else begin
                    e = q.pop_front();
                    if (stopb) begin
                        chk("R2", "start bit", int'(startb), 0);
                        chk("R2", "frame kind", 0, int'(e.brk));
                        chk("R2", "frame data", int'(got), e.val);
                    end else begin
                        low = 152 * d + 1;
                        while (!tx_line) begin
                            @(negedge clk);
                            if (!tx_line) low++;
                        end
                        chk("R10", "break kind", 1, int'(e.brk));
                        chk("R10", "break length", low, e.val);
                    end
                end
            end
            prev = tx_line;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        finish_run();
    end

    initial begin
        int k;
        repeat (4) @(negedge clk);
        chk("R1", "line in reset", int'(tx_line), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "buf_empty", int'(buf_empty), 1);
        chk("R1", "path_idle", int'(path_idle), 1);
        chk("R1", "line", int'(tx_line), 1);
        chk("R1", "irq_done masked", int'(irq_done), 0);
        chk("R8", "irq_buf masked", int'(irq_buf), 0);

        tx_enable = 1'b1;
        irq_empty_en = 1'b1;
        irq_done_en = 1'b1;
        @(negedge clk);
        chk("R8", "irq_done on", int'(irq_done), 1);

        // R3, R5, R8: single byte
        do_write(8'hA5, 1'b1);
        chk("R3", "buf_empty after write", int'(buf_empty), 0);
        chk("R3", "path_idle after write", int'(path_idle), 0);
        chk("R8", "irq_buf low", int'(irq_buf), 0);
        chk("R8", "irq_done low", int'(irq_done), 0);
        @(negedge clk);
        chk("R3", "buf_empty after load", int'(buf_empty), 1);
        chk("R3", "path_idle after load", int'(path_idle), 0);
        chk("R3", "start bit", int'(tx_line), 0);
        chk("R8", "irq_buf high", int'(irq_buf), 1);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!path_idle && k < 1000);
        chk("R5", "drain delay", k, 160);
        repeat (5) @(negedge clk);

        // R4: second byte while first shifts
        do_write(8'h3C, 1'b1);
        repeat (20) @(negedge clk);
        do_write(8'hC3, 1'b1);
        chk("R4", "buf_empty while held", int'(buf_empty), 0);
        repeat (100) @(negedge clk);
        chk("R4", "buf still full", int'(buf_empty), 0);
        wait_idle();
        repeat (5) @(negedge clk);

        // R6: overwrite when full
        do_write(8'h11, 1'b1);
        repeat (20) @(negedge clk);
        do_write(8'h22, 1'b0);
        do_write(8'h33, 1'b1);
        wait_idle();
        repeat (5) @(negedge clk);

        // R7: write in the transfer cycle
        wr_en = 1'b1;
        wr_data = 8'h5A;
        push_data_pair();
        @(negedge clk);
        wr_data = 8'h96;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7", "new byte held", int'(buf_empty), 0);
        chk("R7", "old byte started", int'(tx_line), 0);
        wait_idle();
        repeat (5) @(negedge clk);

        // R9: transmitter disabled
        tx_enable = 1'b0;
        @(negedge clk);
        chk("R9", "tx_oe off", int'(tx_oe), 0);
        do_write(8'h81, 1'b1);
        repeat (50) @(negedge clk);
        chk("R9", "byte waits", int'(buf_empty), 0);
        chk("R9", "not drained", int'(path_idle), 0);
        chk("R9", "line high", int'(tx_line), 1);
        tx_enable = 1'b1;
        wait_idle();
        repeat (5) @(negedge clk);

        // R10: two-character break
        push_break(320);
        brk_req = 1'b1;
        repeat (200) @(negedge clk);
        brk_req = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R10", "line high after break", int'(tx_line), 1);

        // R10: break ahead of a held byte
        push_break(160);
        brk_req = 1'b1;
        do_write(8'h7E, 1'b1);
        repeat (10) @(negedge clk);
        brk_req = 1'b0;
        chk("R10", "byte held during break", int'(buf_empty), 0);
        wait_idle();
        repeat (5) @(negedge clk);

        // R11: sparse baud ticks
        div = 3;
        repeat (6) @(negedge clk);
        do_write(8'hE7, 1'b1);
        repeat (300) @(negedge clk);
        chk("R11", "still sending", int'(path_idle), 0);
        wait_idle();
        div = 1;
        repeat (20) @(negedge clk);

        chk("R2", "scoreboard drained", q.size(), 0);
        finish_run();
    end

    task automatic push_data_pair();
        exp_t e;
        e.brk = 1'b0; e.val = 32'h5A; q.push_back(e);
        e.val = 32'h96; q.push_back(e);
    endtask

endmodule